// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point words and returns their rounded sum one clock later. Each word carries a sign in bit 31, an 8-bit biased exponent in bits 30..23 (real exponent = field - 127, normal fields 1..254) and a 23-bit fraction in bits 22..0 with a hidden leading one. The datapath swaps the operands so the larger magnitude leads, shifts the smaller significand right by the exponent gap while folding every lost bit into a sticky bit, adds or subtracts, renormalises to a single integer bit, and rounds to nearest with ties to even.

Special words are settled on a separate path: an exponent field of 255 marks infinity (zero fraction) or NaN (nonzero fraction), and an exponent field of 0 is taken as zero whatever its fraction holds. Results too large for field 254 become a signed infinity; results below the normal range, and exact cancellations, become +0.

Both edges of the block are valid/ready streams. An operand pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result register raises `out_valid` on the next edge and holds `out_result` unchanged until a clock edge with `out_ready` high. `in_ready` is high whenever the result register is empty or is being drained in the same cycle, so a full-rate stream runs with no bubbles while `out_ready` stays high, and stalls without loss when it falls.

Top module: `fpadd_sp`

## Requirements
- R1: With equal signs and normal operands the result is the rounded sum (1.0+2.0 = 0x40400000, -1.0 + -2.0 = 0xC0400000).
- R2: The smaller operand is aligned by the exponent difference; a gap wider than the significand leaves the larger operand (1.0 + 2^-30 = 0x3F800000) and smaller gaps add exactly (4.0+1.0 = 0x40A00000).
- R3: With opposite signs the smaller magnitude is subtracted from the larger, the result takes the larger operand's sign and is shifted left to renormalise (1.0 - 0.75 = 0x3E800000, 0.75 - 1.0 = 0xBE800000).
- R4: Rounding is to nearest; an exact half goes to the even fraction (1.0 + 2^-24 = 0x3F800000, 0x3F800001 + 2^-24 = 0x3F800002, 1.0 + 1.5*2^-24 = 0x3F800001).
- R5: A rounding increment that carries out of the significand raises the exponent by one (0x3FFFFFFF + 2^-24 = 0x40000000).
- R6: A result whose exponent field would reach 255 or more becomes infinity with the result sign (0x7F7FFFFF twice = 0x7F800000, 0xFF7FFFFF twice = 0xFF800000).
- R7: Any NaN operand, or infinities of opposite sign, give exactly 0x7FC00000; no other NaN pattern is ever output.
- R8: An infinity plus a finite value, or plus an infinity of the same sign, gives that infinity.
- R9: A zero operand (exponent field 0, any fraction) returns the other operand unchanged; two zeros give zero whose sign is set only if both signs are set.
- R10: Exact cancellation and results below exponent field 1 give +0 (0x00000000); the output never has exponent field 0 with a nonzero fraction.
- R11: A pair accepted on an edge gives `out_valid` high after that edge; while `out_valid` is high and `out_ready` low, the result holds and `in_ready` is low; a drained register with no new pair drops `out_valid`.
- R12: During and right after reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | 32 | First operand word |
| in_b | input | 32 | Second operand word |
| out_valid | output | 1 | Result register holds an untaken result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Rounded sum word |

## Verification
The checker assumes the consumer's `out_ready` and the producer's `in_valid` are plain levels sampled at the clock edge and that reset is held for at least one edge; it makes no assumption about operand values, since every 32-bit pattern decodes to a zero, normal, infinity or NaN. The directed stimulus changes inputs only on falling edges, keeps `in_valid` high across a stall so that the back-pressure rule is exercised with a pending pair, and chooses operands whose exact sums are easy to derive by hand, including the half-way and carry-out rounding points, the top of the exponent range and the cancellation down to below the normal range.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  parameter int EXP_W  = 8;
  parameter int FRAC_W = 23;

  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int GRS_W   = 3;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int EXT_W   = MANT_W + GRS_W;
  localparam int SUM_W   = EXT_W + 1;
  localparam int NEXP_W  = EXP_W + 2;
  localparam int LZ_W    = $clog2(EXT_W + 1);
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;

  localparam fp_word_t QNAN_WORD = '{sign: 1'b0, exp: {EXP_W{1'b1}},
                                     frac: {1'b1, {(FRAC_W-1){1'b0}}}};
endpackage

// File: rtl/fpadd_special.sv
module fpadd_special
  import fpadd_pkg::*;
(
  input  fp_word_t op_a,
  input  fp_word_t op_b,
  output logic     bypass,
  output fp_word_t bypass_word
);
  logic a_top, b_top, a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;

  always_comb begin
    a_top  = (op_a.exp == {EXP_W{1'b1}});
    b_top  = (op_b.exp == {EXP_W{1'b1}});
    a_nan  = a_top && (op_a.frac != '0);
    b_nan  = b_top && (op_b.frac != '0);
    a_inf  = a_top && (op_a.frac == '0);
    b_inf  = b_top && (op_b.frac == '0);
    a_zero = (op_a.exp == '0);
    b_zero = (op_b.exp == '0);
  end

  // Fixed priority: NaN, clashing infinities, single infinity, zeros.
  always_comb begin
    bypass      = 1'b1;
    bypass_word = QNAN_WORD;
    if (a_nan || b_nan) begin
      bypass_word = QNAN_WORD;
    end else if (a_inf && b_inf && (op_a.sign != op_b.sign)) begin
      bypass_word = QNAN_WORD;
    end else if (a_inf) begin
      bypass_word = op_a;
    end else if (b_inf) begin
      bypass_word = op_b;
    end else if (a_zero && b_zero) begin
      bypass_word = '{sign: op_a.sign & op_b.sign, exp: '0, frac: '0};
    end else if (a_zero) begin
      bypass_word = op_b;
    end else if (b_zero) begin
      bypass_word = op_a;
    end else begin
      bypass = 1'b0;
    end
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
(
  input  fp_word_t           op_a,
  input  fp_word_t           op_b,
  output logic               lead_sign,
  output logic [EXP_W-1:0]   lead_exp,
  output logic               do_sub,
  output logic [EXT_W-1:0]   lead_ext,
  output logic [EXT_W-1:0]   trail_ext
);
  fp_word_t         big_w, small_w;
  logic [EXP_W-1:0] gap;
  logic [EXT_W-1:0] trail_full, shifted, lost;
  logic             sticky;

  always_comb begin
    if ({op_a.exp, op_a.frac} >= {op_b.exp, op_b.frac}) begin
      big_w   = op_a;
      small_w = op_b;
    end else begin
      big_w   = op_b;
      small_w = op_a;
    end
    lead_sign  = big_w.sign;
    lead_exp   = big_w.exp;
    do_sub     = op_a.sign ^ op_b.sign;
    gap        = big_w.exp - small_w.exp;
    lead_ext   = {1'b1, big_w.frac, {GRS_W{1'b0}}};
    trail_full = {1'b1, small_w.frac, {GRS_W{1'b0}}};
    if (gap >= EXP_W'(EXT_W)) begin
      shifted = '0;
      lost    = trail_full;
    end else begin
      shifted = trail_full >> gap;
      lost    = trail_full & ~({EXT_W{1'b1}} << gap);
    end
    sticky    = |lost;
    trail_ext = {shifted[EXT_W-1:1], shifted[0] | sticky};
  end
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
  import fpadd_pkg::*;
(
  input  logic [EXP_W-1:0]  lead_exp,
  input  logic              do_sub,
  input  logic [EXT_W-1:0]  lead_ext,
  input  logic [EXT_W-1:0]  trail_ext,
  output logic [EXT_W-1:0]  norm_mant,
  output logic [NEXP_W-1:0] norm_exp,
  output logic              sum_zero
);
  logic [SUM_W-1:0]  raw;
  logic [LZ_W-1:0]   lead_zeros;
  logic              hit;
  logic [NEXP_W-1:0] exp_wide;

  always_comb begin
    if (do_sub) raw = {1'b0, lead_ext} - {1'b0, trail_ext};
    else        raw = {1'b0, lead_ext} + {1'b0, trail_ext};
    sum_zero = (raw == '0);
  end

  always_comb begin
    lead_zeros = '0;
    hit        = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!hit && raw[i]) begin
        lead_zeros = LZ_W'(EXT_W - 1 - i);
        hit        = 1'b1;
      end
    end
  end

  always_comb begin
    exp_wide = {2'b00, lead_exp};
    if (raw[SUM_W-1]) begin
      norm_mant = {raw[SUM_W-1:2], raw[1] | raw[0]};
      norm_exp  = exp_wide + NEXP_W'(1);
    end else begin
      norm_mant = raw[EXT_W-1:0] << lead_zeros;
      norm_exp  = exp_wide - NEXP_W'(lead_zeros);
    end
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  logic              res_sign,
  input  logic [EXT_W-1:0]  norm_mant,
  input  logic [NEXP_W-1:0] norm_exp,
  input  logic              sum_zero,
  output fp_word_t          res_word
);
  logic [MANT_W-1:0] keep;
  logic              g_bit, r_bit, s_bit, bump;
  logic [MANT_W:0]   rounded;
  logic [MANT_W-1:0] carried;
  logic [NEXP_W-1:0] exp_r;
  logic [FRAC_W-1:0] frac_r;
  logic              under, over;

  always_comb begin
    keep    = norm_mant[EXT_W-1:GRS_W];
    g_bit   = norm_mant[GRS_W-1];
    r_bit   = norm_mant[GRS_W-2];
    s_bit   = |norm_mant[GRS_W-3:0];
    bump    = g_bit & (r_bit | s_bit | keep[0]);
    rounded = {1'b0, keep} + (MANT_W+1)'(bump);
    carried = rounded[MANT_W:1];
    if (rounded[MANT_W]) begin
      exp_r  = norm_exp + NEXP_W'(1);
      frac_r = carried[FRAC_W-1:0];
    end else begin
      exp_r  = norm_exp;
      frac_r = rounded[FRAC_W-1:0];
    end
    under = exp_r[NEXP_W-1] || (exp_r == '0);
    over  = !exp_r[NEXP_W-1] && (exp_r[NEXP_W-2:0] >= (NEXP_W-1)'(EXP_MAX));
  end

  always_comb begin
    if (sum_zero || under) begin
      res_word = '{sign: 1'b0, exp: '0, frac: '0};
    end else if (over) begin
      res_word = '{sign: res_sign, exp: {EXP_W{1'b1}}, frac: '0};
    end else begin
      res_word = '{sign: res_sign, exp: exp_r[EXP_W-1:0], frac: frac_r};
    end
  end
endmodule

// File: rtl/fpadd_sp.sv
module fpadd_sp
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result
);
  fp_word_t          op_a, op_b, bypass_word, arith_word, next_word;
  logic              bypass;
  logic              lead_sign, do_sub, sum_zero;
  logic [EXP_W-1:0]  lead_exp;
  logic [EXT_W-1:0]  lead_ext, trail_ext, norm_mant;
  logic [NEXP_W-1:0] norm_exp;
  logic              take;

  assign op_a = fp_word_t'(in_a);
  assign op_b = fp_word_t'(in_b);

  fpadd_special u_special (
    .op_a        (op_a),
    .op_b        (op_b),
    .bypass      (bypass),
    .bypass_word (bypass_word)
  );

  fpadd_align u_align (
    .op_a      (op_a),
    .op_b      (op_b),
    .lead_sign (lead_sign),
    .lead_exp  (lead_exp),
    .do_sub    (do_sub),
    .lead_ext  (lead_ext),
    .trail_ext (trail_ext)
  );

  fpadd_norm u_norm (
    .lead_exp  (lead_exp),
    .do_sub    (do_sub),
    .lead_ext  (lead_ext),
    .trail_ext (trail_ext),
    .norm_mant (norm_mant),
    .norm_exp  (norm_exp),
    .sum_zero  (sum_zero)
  );

  fpadd_round u_round (
    .res_sign  (lead_sign),
    .norm_mant (norm_mant),
    .norm_exp  (norm_exp),
    .sum_zero  (sum_zero),
    .res_word  (arith_word)
  );

  assign next_word = bypass ? bypass_word : arith_word;
  assign in_ready  = !out_valid || out_ready;
  assign take      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= next_word;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/fpadd_sp_chk.sv
module fpadd_sp_chk
  import fpadd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_result
);
  // R11
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R11
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_result[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}})
               && (out_result[FRAC_W-1:0] != '0)) |-> (out_result == QNAN_WORD));

  // R10
  no_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_result[WORD_W-2 -: EXP_W] == '0)) |-> (out_result[FRAC_W-1:0] == '0));
endmodule

bind fpadd_sp fpadd_sp_chk i_fpadd_sp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/test_fpadd_sp.sv
module test_fpadd_sp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fpadd_sp i_fpadd_sp (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
    n_checks++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, want);
    end
  endtask

  task automatic add_one(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] want);
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check(tag, out_result, want);
  endtask

  task automatic t_reset();
    // R12
    check("R12 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R12 in_ready in reset", {31'd0, in_ready}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R12 out_valid after reset", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_same_sign();
    add_one("R1 1+2", 32'h3F800000, 32'h40000000, 32'h40400000);
    add_one("R1 1.5+1.5", 32'h3FC00000, 32'h3FC00000, 32'h40400000);
    add_one("R1 -1+-2", 32'hBF800000, 32'hC0000000, 32'hC0400000);
  endtask

  task automatic t_align();
    add_one("R2 wide gap", 32'h3F800000, 32'h30800000, 32'h3F800000);
    add_one("R2 4+1", 32'h40800000, 32'h3F800000, 32'h40A00000);
  endtask

  task automatic t_subtract();
    add_one("R3 1-0.75", 32'h3F800000, 32'hBF400000, 32'h3E800000);
    add_one("R3 0.75-1", 32'h3F400000, 32'hBF800000, 32'hBE800000);
  endtask

  task automatic t_round();
    add_one("R4 tie to even down", 32'h3F800000, 32'h33800000, 32'h3F800000);
    add_one("R4 tie to even up", 32'h3F800001, 32'h33800000, 32'h3F800002);
    add_one("R4 above half", 32'h3F800000, 32'h33C00000, 32'h3F800001);
    add_one("R5 round carry", 32'h3FFFFFFF, 32'h33800000, 32'h40000000);
  endtask

  task automatic t_overflow();
    add_one("R6 pos overflow", 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000);
    add_one("R6 neg overflow", 32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000);
  endtask

  task automatic t_specials();
    add_one("R7 nan operand", 32'h7F800001, 32'h3F800000, 32'h7FC00000);
    add_one("R7 neg nan vs zero", 32'hFFFFFFFF, 32'h00000000, 32'h7FC00000);
    add_one("R7 inf minus inf", 32'h7F800000, 32'hFF800000, 32'h7FC00000);
    add_one("R7 inf plus nan", 32'h7F800000, 32'h7FC12345, 32'h7FC00000);
    add_one("R8 inf plus finite", 32'h7F800000, 32'hBF800000, 32'h7F800000);
    add_one("R8 finite plus neg inf", 32'h40000000, 32'hFF800000, 32'hFF800000);
    add_one("R8 inf plus inf", 32'h7F800000, 32'h7F800000, 32'h7F800000);
  endtask

  task automatic t_zeros();
    add_one("R9 x plus zero", 32'h3F800000, 32'h00000000, 32'h3F800000);
    add_one("R9 zero plus x", 32'h00000000, 32'hC0400000, 32'hC0400000);
    add_one("R9 zero field with fraction", 32'h3F800000, 32'h00012345, 32'h3F800000);
    add_one("R9 neg zeros", 32'h80000000, 32'h80000000, 32'h80000000);
    add_one("R9 mixed zeros", 32'h80000000, 32'h00000000, 32'h00000000);
    add_one("R10 cancel", 32'h3F800000, 32'hBF800000, 32'h00000000);
    add_one("R10 below normal", 32'h00C00000, 32'h80800000, 32'h00000000);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_a = 32'h3F800000; in_b = 32'h40000000; in_valid = 1'b1;
    @(negedge clk);
    check("R11 first result valid", {31'd0, out_valid}, 32'd1);
    check("R11 first result", out_result, 32'h40400000);
    in_a = 32'h40800000; in_b = 32'h3F800000;
    check("R11 in_ready low when stalled", {31'd0, in_ready}, 32'd0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R11 held valid", {31'd0, out_valid}, 32'd1);
      check("R11 held result", out_result, 32'h40400000);
    end
    out_ready = 1'b1;
    #1;
    check("R11 in_ready on drain", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 second valid", {31'd0, out_valid}, 32'd1);
    check("R11 second result", out_result, 32'h40A00000);
    @(negedge clk);
    check("R11 drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #2;
    t_reset();
    t_same_sign();
    t_align();
    t_subtract();
    t_round();
    t_overflow();
    t_specials();
    t_zeros();
    t_backpressure();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule